// File: doc/BRIEF.md
# CISC Operand Addressing Unit

This block takes one 16-bit instruction word together with the address of the word that follows it. It works out where the instruction's operand lives, or where a branch goes. It sorts the instruction into one of four classes and reads a 3-bit addressing mode, which is two type bits plus an indirection bit. It then runs a short sequence. That sequence fetches the optional extension word W when the mode needs one, adds W to a register or to the program counter, and, for indirect indexed or PC-relative modes, makes one more memory read to get the final address. The result comes out as a single value. A flag says whether the value is an operand or a memory address, a second flag says which operand (source or destination) the mode applied to, and a third flag marks an addressing mode that is not allowed.

Instructions enter on a valid/ready handshake. The unit takes a new word only while it is idle, and `in_ready` is high only then. Results leave on a valid/ready handshake. Once `out_valid` is high it stays high, and all result fields hold steady, until a cycle in which `out_ready` is also high. Memory reads use a plain request/valid pair. `mem_req` and `mem_addr` are held until a cycle in which the memory drives `mem_rvalid` with the data. The register file is read combinationally through `reg_idx`/`reg_data`.

Instruction layout: bits 15:14 hold the class, bits 13:10 the opcode (ignored here), bits 9:8 the mode type, bit 7 the indirection bit, bit 6 the side bit S, bits 5:3 the source register and bits 2:0 the destination register.

Top module: `opaddr_unit`

## Requirements
- R1: Class 00 (no explicit operand) produces a result of value 0 with all three flags low and makes no memory request.
- R2: The mode register is the source field (bits 5:3) for class 10 with S=0, and the destination field (bits 2:0) otherwise. `out_on_dst` is 1 for classes 01 and 11 and for class 10 with S=1.
- R3: Mode type 00 (register) fetches no W. The result is the mode register's contents, flagged as an address when the indirection bit is set and as an operand otherwise.
- R4: Mode types 01, 10 and 11 read W from address `in_pc` as the first memory request. Type 01 gives W as an operand, or gives W as a direct address when the indirection bit is set, with no further read.
- R5: Type 10 (indexed) gives address W + register, modulo 2^16. With the indirection bit set, that sum is read as a pointer and the data read back is the result address.
- R6: Type 11 (PC-relative) gives address W + `in_pc` + 1, modulo 2^16. The indirection bit works as in R5.
- R7: A branch (class 11) with mode type 00 sets `out_illegal`, gives value 0 and makes no memory request.
- R8: A memory request keeps `mem_req` high and `mem_addr` steady until `mem_rvalid`, for any response delay.
- R9: While `out_valid` is high and `out_ready` is low, the result and its flags stay unchanged.
- R10: After reset `in_ready` is 1 and `out_valid` and `mem_req` are 0. `in_ready` is 1 only when no result is pending and no memory request is open.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word offered |
| in_ready | output | 1 | Unit idle, instruction accepted this cycle if offered |
| in_ir | input | 16 | Instruction word |
| in_pc | input | DATA_W | Address of the word following the instruction |
| reg_idx | output | 3 | Register file read index |
| reg_data | input | DATA_W | Register file read data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | DATA_W | Memory read address |
| mem_rvalid | input | 1 | Memory read data valid, completes the request |
| mem_rdata | input | DATA_W | Memory read data |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_value | output | DATA_W | Effective address or operand value |
| out_is_addr | output | 1 | 1: value is a memory address, 0: value is an operand |
| out_on_dst | output | 1 | Mode applied to the destination operand |
| out_illegal | output | 1 | Addressing mode not allowed for this class |

## Verification
The hardest path to reach is an indirect indexed or PC-relative access. In that case a second memory request must start right after the W read completes, and its address must come from an addition that involves the register port or a wrapped program counter. The bench sweeps every class, mode and side bit against three program counter values, one of them at the top of the address space. A memory responder with a delay of 0 to 2 cycles checks that both request addresses are correct. A consumer that holds `out_ready` low for several cycles exercises back-pressure on the result.

// File: rtl/opaddr_pkg.sv
package opaddr_pkg;

  localparam int IR_W = 16;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'b00,
    CLS_ONE    = 2'b01,
    CLS_TWO    = 2'b10,
    CLS_BRANCH = 2'b11
  } iclass_e;

  typedef enum logic [1:0] {
    AM_REG   = 2'b00,
    AM_IMM   = 2'b01,
    AM_IDX   = 2'b10,
    AM_PCREL = 2'b11
  } amode_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_W,
    ST_CALC,
    ST_INDIRECT,
    ST_DONE
  } seq_state_e;

  typedef struct packed {
    iclass_e    cls;
    logic [3:0] op;
    amode_e     am;
    logic       ind;
    logic       need_w;
    logic       need_ptr;
    logic       on_dst;
    logic       illegal;
    logic [2:0] reg_sel;
  } dec_t;

endpackage

// File: rtl/opaddr_decode.sv
module opaddr_decode
  import opaddr_pkg::*;
(
  input  logic [IR_W-1:0] ir,
  output dec_t            dec
);
  logic src_side;
  logic no_operand;

  always_comb begin
    dec.cls  = iclass_e'(ir[15:14]);
    dec.op   = ir[13:10];
    dec.am   = amode_e'(ir[9:8]);
    dec.ind  = ir[7];
    src_side   = (dec.cls == CLS_TWO) && !ir[6];
    no_operand = (dec.cls == CLS_NONE);
    dec.reg_sel  = src_side ? ir[5:3] : ir[2:0];
    dec.on_dst   = !no_operand && !src_side;
    dec.illegal  = (dec.cls == CLS_BRANCH) && (dec.am == AM_REG);
    dec.need_w   = !no_operand && !dec.illegal && (dec.am != AM_REG);
    dec.need_ptr = !no_operand && !dec.illegal && dec.ind &&
                   ((dec.am == AM_IDX) || (dec.am == AM_PCREL));
  end
endmodule

// File: rtl/opaddr_agen.sv
module opaddr_agen
  import opaddr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_STEP = 1
) (
  input  amode_e            am,
  input  logic              ind,
  input  logic [DATA_W-1:0] w,
  input  logic [DATA_W-1:0] reg_data,
  input  logic [DATA_W-1:0] pc,
  output logic [DATA_W-1:0] gen,
  output logic              gen_is_addr
);
  localparam logic [DATA_W-1:0] STEP = DATA_W'(PC_STEP);

  always_comb begin
    unique case (am)
      AM_REG: begin
        gen         = reg_data;
        gen_is_addr = ind;
      end
      AM_IMM: begin
        gen         = w;
        gen_is_addr = ind;
      end
      AM_IDX: begin
        gen         = w + reg_data;
        gen_is_addr = 1'b1;
      end
      default: begin
        gen         = w + pc + STEP;
        gen_is_addr = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/opaddr_seq.sv
module opaddr_seq
  import opaddr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [IR_W-1:0]   in_ir,
  input  logic [DATA_W-1:0] in_pc,
  input  dec_t              dec,
  input  logic [DATA_W-1:0] gen,
  input  logic              gen_is_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              out_ready,
  output logic              idle,
  output logic [IR_W-1:0]   ir_q,
  output logic [DATA_W-1:0] pc_q,
  output logic [DATA_W-1:0] w_q,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_q,
  output logic              is_addr_q,
  output logic              on_dst_q,
  output logic              illegal_q
);
  seq_state_e state;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ir_q      <= '0;
      pc_q      <= '0;
      w_q       <= '0;
      res_q     <= '0;
      is_addr_q <= 1'b0;
      on_dst_q  <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (in_valid) begin
          ir_q      <= in_ir;
          pc_q      <= in_pc;
          w_q       <= '0;
          res_q     <= '0;
          is_addr_q <= 1'b0;
          on_dst_q  <= dec.on_dst;
          illegal_q <= dec.illegal;
          if (dec.cls == CLS_NONE || dec.illegal) state <= ST_DONE;
          else if (dec.need_w)                    state <= ST_FETCH_W;
          else                                    state <= ST_CALC;
        end
        ST_FETCH_W: if (mem_rvalid) begin
          w_q   <= mem_rdata;
          state <= ST_CALC;
        end
        ST_CALC: begin
          res_q     <= gen;
          is_addr_q <= gen_is_addr;
          state     <= dec.need_ptr ? ST_INDIRECT : ST_DONE;
        end
        ST_INDIRECT: if (mem_rvalid) begin
          res_q <= mem_rdata;
          state <= ST_DONE;
        end
        default: if (out_ready) state <= ST_IDLE;
      endcase
    end
  end

  assign idle      = (state == ST_IDLE);
  assign mem_req   = (state == ST_FETCH_W) || (state == ST_INDIRECT);
  assign mem_addr  = (state == ST_FETCH_W) ? pc_q : res_q;
  assign out_valid = (state == ST_DONE);
endmodule

// File: rtl/opaddr_unit.sv
module opaddr_unit
  import opaddr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_STEP = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [15:0]       in_ir,
  input  logic [DATA_W-1:0] in_pc,
  output logic [2:0]        reg_idx,
  input  logic [DATA_W-1:0] reg_data,
  output logic              mem_req,
  output logic [DATA_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_value,
  output logic              out_is_addr,
  output logic              out_on_dst,
  output logic              out_illegal
);
  logic              idle;
  logic [IR_W-1:0]   ir_q;
  logic [IR_W-1:0]   ir_view;
  logic [DATA_W-1:0] pc_q;
  logic [DATA_W-1:0] w_q;
  logic [DATA_W-1:0] gen;
  logic              gen_is_addr;
  dec_t              dec;

  // Decode the offered word while idle, the held word afterwards.
  assign ir_view = idle ? in_ir : ir_q;

  opaddr_decode u_dec (
    .ir  (ir_view),
    .dec (dec)
  );

  opaddr_agen #(.DATA_W(DATA_W), .PC_STEP(PC_STEP)) u_agen (
    .am          (dec.am),
    .ind         (dec.ind),
    .w           (w_q),
    .reg_data    (reg_data),
    .pc          (pc_q),
    .gen         (gen),
    .gen_is_addr (gen_is_addr)
  );

  opaddr_seq #(.DATA_W(DATA_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_ir       (in_ir),
    .in_pc       (in_pc),
    .dec         (dec),
    .gen         (gen),
    .gen_is_addr (gen_is_addr),
    .mem_rvalid  (mem_rvalid),
    .mem_rdata   (mem_rdata),
    .out_ready   (out_ready),
    .idle        (idle),
    .ir_q        (ir_q),
    .pc_q        (pc_q),
    .w_q         (w_q),
    .mem_req     (mem_req),
    .mem_addr    (mem_addr),
    .out_valid   (out_valid),
    .res_q       (out_value),
    .is_addr_q   (out_is_addr),
    .on_dst_q    (out_on_dst),
    .illegal_q   (out_illegal)
  );

  assign in_ready = idle;
  assign reg_idx  = dec.reg_sel;
endmodule

// File: rtl/opaddr_unit_chk.sv
module opaddr_unit_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [15:0]       in_ir,
  input logic              mem_req,
  input logic [DATA_W-1:0] mem_addr,
  input logic              mem_rvalid,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_value,
  input logic              out_is_addr,
  input logic              out_on_dst,
  input logic              out_illegal
);
  logic take;
  assign take = in_valid && in_ready;

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))); // R8

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_value) &&
      $stable(out_is_addr) && $stable(out_on_dst) && $stable(out_illegal))); // R9

  AST_BRANCH_REG_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_ir[15:14] == 2'b11 && in_ir[9:8] == 2'b00) |=>
      (out_valid && out_illegal && !mem_req)); // R7

  AST_NOOP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_ir[15:14] == 2'b00) |=>
      (out_valid && !out_illegal && !out_is_addr && out_value == '0)); // R1

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (!out_valid && !mem_req)); // R10
endmodule

bind opaddr_unit opaddr_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_ir       (in_ir),
  .mem_req     (mem_req),
  .mem_addr    (mem_addr),
  .mem_rvalid  (mem_rvalid),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_value   (out_value),
  .out_is_addr (out_is_addr),
  .out_on_dst  (out_on_dst),
  .out_illegal (out_illegal)
);

// File: tb/opaddr_unit_tb.sv
`timescale 1ns/1ps
module opaddr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_ir = '0;
  logic [15:0] in_pc = '0;
  logic [2:0]  reg_idx;
  logic [15:0] reg_data;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_value;
  logic        out_is_addr;
  logic        out_on_dst;
  logic        out_illegal;

  int checks = 0;
  int errors = 0;
  int lat = 0;
  int wait_cnt = 0;
  int nreq = 0;
  logic [15:0] req_log [0:3];

  always #10 clk = ~clk;

  function automatic logic [15:0] memf(input logic [15:0] a);
    return a * 16'd3 + 16'h1357;
  endfunction

  function automatic logic [15:0] regval(input logic [2:0] i);
    return 16'hF00D + {13'd0, i} * 16'h01F3;
  endfunction

  assign reg_data = regval(reg_idx);

  opaddr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_ir(in_ir), .in_pc(in_pc), .reg_idx(reg_idx), .reg_data(reg_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .out_valid(out_valid), .out_ready(out_ready),
    .out_value(out_value), .out_is_addr(out_is_addr), .out_on_dst(out_on_dst),
    .out_illegal(out_illegal)
  );

  // Memory responder with a delay of lat cycles per request.
  always @(negedge clk) begin
    if (mem_req) begin
      if (wait_cnt >= lat) begin
        mem_rvalid = 1'b1;
        mem_rdata  = memf(mem_addr);
        if (nreq < 4) req_log[nreq] = mem_addr;
        nreq++;
        wait_cnt = 0;
      end else begin
        mem_rvalid = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_rvalid = 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] cls, input logic [2:0] mode, input logic s,
                     input logic [2:0] src, input logic [2:0] dst,
                     input logic [3:0] op, input logic [15:0] pc, input int stall);
    logic [15:0] e_val, w, g;
    logic        e_addr, e_dst, e_ill;
    int          e_reads;
    logic [2:0]  ri;
    logic [1:0]  t;
    logic        ind;
    t   = mode[2:1];
    ind = mode[0];
    ri  = (cls == 2'b10 && !s) ? src : dst;
    w   = memf(pc);
    e_dst = (cls != 2'b00) && !(cls == 2'b10 && !s);
    e_ill = 1'b0; e_val = '0; e_addr = 1'b0; e_reads = 0; g = '0;
    if (cls == 2'b00) begin
      e_dst = 1'b0;
    end else if (cls == 2'b11 && t == 2'b00) begin
      e_ill = 1'b1;
    end else begin
      case (t)
        2'b00: begin e_val = regval(ri); e_addr = ind; end
        2'b01: begin e_val = w; e_addr = ind; e_reads = 1; end
        default: begin
          g = (t == 2'b10) ? w + regval(ri) : w + pc + 16'd1;
          e_addr = 1'b1;
          e_reads = ind ? 2 : 1;
          e_val = ind ? memf(g) : g;
        end
      endcase
    end

    nreq = 0;
    @(negedge clk);
    in_ir = {cls, op, mode, s, src, dst};
    in_pc = pc;
    in_valid = 1'b1;
    check(in_ready === 1'b1, "R10 ready while idle", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    in_ir = 16'hFFFF;
    in_pc = 16'h0BAD;
    while (!out_valid) @(negedge clk);
    check(in_ready === 1'b0, "R10 not ready with result", {31'd0, in_ready}, 32'd0);
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      check(out_valid === 1'b1 && out_value === e_val, "R9 result held",
            {16'd0, out_value}, {16'd0, e_val});
    end
    check(out_value === e_val, (t == 2'b10) ? "R5 value" : (t == 2'b11) ? "R6 value" :
          (t == 2'b01) ? "R4 value" : "R3 value", {16'd0, out_value}, {16'd0, e_val});
    check(out_is_addr === e_addr, "R3 R4 R5 R6 address flag",
          {31'd0, out_is_addr}, {31'd0, e_addr});
    check(out_on_dst === e_dst, "R2 side flag", {31'd0, out_on_dst}, {31'd0, e_dst});
    check(out_illegal === e_ill, "R7 illegal flag", {31'd0, out_illegal}, {31'd0, e_ill});
    check(nreq == e_reads, (cls == 2'b00) ? "R1 request count" : "R4 R7 request count",
          nreq, e_reads);
    if (e_reads >= 1 && nreq >= 1)
      check(req_log[0] === pc, "R4 W address", {16'd0, req_log[0]}, {16'd0, pc});
    if (e_reads == 2 && nreq >= 2)
      check(req_log[1] === g, "R5 R6 pointer address", {16'd0, req_log[1]}, {16'd0, g});
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid === 1'b0, "R9 released", {31'd0, out_valid}, 32'd0);
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready === 1'b1, "R10 reset ready", {31'd0, in_ready}, 32'd1);
    check(out_valid === 1'b0, "R10 reset out_valid", {31'd0, out_valid}, 32'd0);
    check(mem_req === 1'b0, "R10 reset mem_req", {31'd0, mem_req}, 32'd0);
    for (int pi = 0; pi < 3; pi++) begin
      for (int c = 0; c < 4; c++) begin
        for (int m = 0; m < 8; m++) begin
          for (int s = 0; s < 2; s++) begin
            lat = (m + s + pi) % 3;
            run(2'(c), 3'(m), 1'(s), 3'(pi + 5), 3'(pi * 3 + 2), 4'(m + c),
                (pi == 0) ? 16'h0040 : (pi == 1) ? 16'hFFFF : 16'h8001,
                (m + c) % 3);
          end
        end
      end
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule